// File: doc/BRIEF.md
# Memory Clock Switch Sequencer

This block moves a DRAM interface from one memory clock to another without losing stored data or corrupting the picture. A single start pulse launches a fixed run. The block waits for the active display heads to be scanning and then blanking. It blanks scanout and cuts bus access, then parks the DRAM controller in self-refresh. It then reprograms the memory PLL through a bypass step, brings the controller back out of self-refresh and waits for the PLL to lock. Finally it reopens the bus and the display.

Every register access leaves through one write-request port with a valid/ready handshake. Register addresses are parameters. The PLL divider values N, M and P are worked out elsewhere and arrive as inputs with the target frequency. These inputs, the active-head mask, the scanout-capability flag and the wait limit are all captured on the start pulse. A microsecond tick input times the settling delays. A cycle-count limit guards each blanking wait.

Top module: `mem_reclock_seq`

## Requirements
- R1: After reset, busy, done, timeout_err and wr_valid are all 0.
- R2: If any bit of head_active is set at start, no write is offered until every active head shows head_scanout, and after that until every active head shows head_vblank. Heads that are not active are ignored.
- R3: The first memory writes come in this order: bus off (addr 0x21, data 0), precharge/idle (0x30, 1), one forced refresh (0x31, 1), auto-refresh off (0x32, 0), self-refresh on (0x33, 1).
- R4: The clock change then writes, in order: source select (0x40, data 1), PLL control with bypass (0x41, captured ctrl_now OR 0x200), coefficient (0x42, N in bits 15:8 and M in bits 7:0), and then the final PLL control (0x41).
- R5: When the PLL is used, the final control word is (ctrl_now AND NOT 0x81FF0200) OR bit 31 OR P<<22 OR P<<16.
- R6: When target_hz/1000 equals REF_HZ/1000 (default REF_HZ 100000000), the final control word is (ctrl_now AND NOT 0x81FF0200) OR 0x200, with bit 31 clear. A target that differs at kHz granularity uses the PLL.
- R7: The restart writes, in order: precharge/idle (0x30, 1), self-refresh off (0x33, 0), and auto-refresh on (0x32, 0x80000000).
- R8: The bus-on write (0x21, data 1) is offered only after 12 and then 48 further us_tick pulses (60 in total) have arrived after the auto-refresh-on write was accepted.
- R9: The scanout-off write (0x20, data 0) comes first and the scanout-on write (0x20, data 1) comes last, and only when scan_cap was 1 at start.
- R10: busy is high from the start pulse until the last write is accepted. done then pulses for one cycle. A start received while busy is ignored, and input changes during a run do not alter the run.
- R11: While wr_valid is high and wr_ready is low, the address and data stay stable. Each step advances only when a write is accepted.
- R12: If a blanking wait stays unmet for more than wait_limit cycles, the run ends with done and timeout_err set and no write issued. timeout_err clears at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| target_hz | input | 32 | Target memory clock in Hz |
| pll_n | input | 8 | PLL feedback divider |
| pll_m | input | 8 | PLL reference divider |
| pll_p | input | 3 | PLL post-divider exponent |
| ctrl_now | input | 32 | Current PLL control word |
| scan_cap | input | 1 | Variant supports scanout disable/enable writes |
| head_active | input | NHEAD | Active display heads |
| head_scanout | input | NHEAD | Per-head scanout indication |
| head_vblank | input | NHEAD | Per-head vertical blank indication |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wait_limit | input | WD_W | Blanking wait limit in cycles |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last run aborted on a blanking wait |

## Verification
With no active head, the first write is offered on the cycle after the edge that samples start. Each later write is offered one cycle after the previous one is accepted. The bench logs every accepted write at the clock edge where valid and ready are both high, and compares the log entry by entry. The bus-on write is offered right after the edge that carries the 60th tick following the auto-refresh-on write, so the bench counts ticks between those two acceptances and keeps ticks away from accepting edges. A timeout shows done exactly wait_limit+1 edges after the edge that samples start, and the bench counts edges up to that point.

// File: rtl/mem_reclock_seq.sv
module mem_reclock_seq #(
  parameter int ADDR_W = 8,
  parameter int NHEAD = 2,
  parameter int WD_W = 16,
  parameter int LOCK_US = 12,
  parameter int SETTLE_US = 48,
  parameter logic [31:0] REF_HZ = 32'd100_000_000,
  parameter logic [ADDR_W-1:0] A_DISP = 8'h20,
  parameter logic [ADDR_W-1:0] A_BUS = 8'h21,
  parameter logic [ADDR_W-1:0] A_PRE = 8'h30,
  parameter logic [ADDR_W-1:0] A_REFNOW = 8'h31,
  parameter logic [ADDR_W-1:0] A_AUTOREF = 8'h32,
  parameter logic [ADDR_W-1:0] A_SELF = 8'h33,
  parameter logic [ADDR_W-1:0] A_SRC = 8'h40,
  parameter logic [ADDR_W-1:0] A_CTRL = 8'h41,
  parameter logic [ADDR_W-1:0] A_COEF = 8'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       target_hz,
  input  logic [7:0]        pll_n,
  input  logic [7:0]        pll_m,
  input  logic [2:0]        pll_p,
  input  logic [31:0]       ctrl_now,
  input  logic              scan_cap,
  input  logic [NHEAD-1:0]  head_active,
  input  logic [NHEAD-1:0]  head_scanout,
  input  logic [NHEAD-1:0]  head_vblank,
  input  logic              us_tick,
  input  logic [WD_W-1:0]   wait_limit,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  localparam int DLY_MAX = (LOCK_US > SETTLE_US) ? LOCK_US : SETTLE_US;
  localparam int DW = $clog2(DLY_MAX + 1);
  localparam logic [31:0] CLR_MASK = 32'h81FF_0200;
  localparam logic [31:0] BYP_BIT = 32'h0000_0200;

  localparam logic [3:0] K_SCAN_OFF = 4'd0;
  localparam logic [3:0] K_BUS_OFF = 4'd1;
  localparam logic [3:0] K_PRE_A = 4'd2;
  localparam logic [3:0] K_REFNOW = 4'd3;
  localparam logic [3:0] K_AUTO_OFF = 4'd4;
  localparam logic [3:0] K_SELF_ON = 4'd5;
  localparam logic [3:0] K_SRC = 4'd6;
  localparam logic [3:0] K_CTRL_BYP = 4'd7;
  localparam logic [3:0] K_COEF = 4'd8;
  localparam logic [3:0] K_CTRL_FIN = 4'd9;
  localparam logic [3:0] K_PRE_B = 4'd10;
  localparam logic [3:0] K_SELF_OFF = 4'd11;
  localparam logic [3:0] K_AUTO_ON = 4'd12;
  localparam logic [3:0] K_BUS_ON = 4'd13;
  localparam logic [3:0] K_SCAN_ON = 4'd14;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_VBL, S_WR, S_LOCK, S_SETL} st_t;

  st_t              state;
  logic [3:0]       step;
  logic [WD_W-1:0]  wd;
  logic [DW-1:0]    dly;
  logic             use_ref_q, cap_q;
  logic [7:0]       n_q, m_q;
  logic [2:0]       p_q;
  logic [31:0]      ctrl_q;
  logic [NHEAD-1:0] act_q;
  logic [WD_W-1:0]  lim_q;
  logic [31:0]      ctrl_base, ctrl_fin;
  logic             hit_ref, last_step;

  assign hit_ref   = (target_hz / 32'd1000) == (REF_HZ / 32'd1000);
  assign ctrl_base = ctrl_q & ~CLR_MASK;
  assign ctrl_fin  = use_ref_q ? (ctrl_base | BYP_BIT)
                   : (ctrl_base | 32'h8000_0000 | ({29'd0, p_q} << 22) | ({29'd0, p_q} << 16));
  assign last_step = (step == K_SCAN_ON) || (step == K_BUS_ON && !cap_q);
  assign wr_valid  = (state == S_WR);
  assign busy      = (state != S_IDLE);

  always_comb begin
    wr_addr = A_BUS;
    wr_data = 32'd0;
    case (step)
      K_SCAN_OFF: begin wr_addr = A_DISP;    wr_data = 32'd0; end
      K_BUS_OFF:  begin wr_addr = A_BUS;     wr_data = 32'd0; end
      K_PRE_A:    begin wr_addr = A_PRE;     wr_data = 32'd1; end
      K_REFNOW:   begin wr_addr = A_REFNOW;  wr_data = 32'd1; end
      K_AUTO_OFF: begin wr_addr = A_AUTOREF; wr_data = 32'd0; end
      K_SELF_ON:  begin wr_addr = A_SELF;    wr_data = 32'd1; end
      K_SRC:      begin wr_addr = A_SRC;     wr_data = 32'd1; end
      K_CTRL_BYP: begin wr_addr = A_CTRL;    wr_data = ctrl_q | BYP_BIT; end
      K_COEF:     begin wr_addr = A_COEF;    wr_data = {16'd0, n_q, m_q}; end
      K_CTRL_FIN: begin wr_addr = A_CTRL;    wr_data = ctrl_fin; end
      K_PRE_B:    begin wr_addr = A_PRE;     wr_data = 32'd1; end
      K_SELF_OFF: begin wr_addr = A_SELF;    wr_data = 32'd0; end
      K_AUTO_ON:  begin wr_addr = A_AUTOREF; wr_data = 32'h8000_0000; end
      K_BUS_ON:   begin wr_addr = A_BUS;     wr_data = 32'd1; end
      K_SCAN_ON:  begin wr_addr = A_DISP;    wr_data = 32'd1; end
      default:    begin wr_addr = A_BUS;     wr_data = 32'd0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= K_SCAN_OFF;
      wd          <= '0;
      dly         <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      use_ref_q   <= 1'b0;
      cap_q       <= 1'b0;
      n_q         <= '0;
      m_q         <= '0;
      p_q         <= '0;
      ctrl_q      <= '0;
      act_q       <= '0;
      lim_q       <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          use_ref_q   <= hit_ref;
          cap_q       <= scan_cap;
          n_q         <= pll_n;
          m_q         <= pll_m;
          p_q         <= pll_p;
          ctrl_q      <= ctrl_now;
          act_q       <= head_active;
          lim_q       <= wait_limit;
          timeout_err <= 1'b0;
          wd          <= '0;
          step        <= scan_cap ? K_SCAN_OFF : K_BUS_OFF;
          state       <= (|head_active) ? S_SCAN : S_WR;
        end
        S_SCAN: begin
          if ((head_scanout & act_q) == act_q) begin
            state <= S_VBL;
            wd    <= '0;
          end else if (wd >= lim_q) begin
            state       <= S_IDLE;
            done        <= 1'b1;
            timeout_err <= 1'b1;
          end else begin
            wd <= wd + 1'b1;
          end
        end
        S_VBL: begin
          if ((head_vblank & act_q) == act_q) begin
            state <= S_WR;
          end else if (wd >= lim_q) begin
            state       <= S_IDLE;
            done        <= 1'b1;
            timeout_err <= 1'b1;
          end else begin
            wd <= wd + 1'b1;
          end
        end
        S_WR: if (wr_ready) begin
          if (step == K_AUTO_ON) begin
            state <= S_LOCK;
            dly   <= '0;
          end else if (last_step) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            step <= step + 4'd1;
          end
        end
        S_LOCK: if (us_tick) begin
          if (dly == DW'(LOCK_US - 1)) begin
            state <= S_SETL;
            dly   <= '0;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        S_SETL: if (us_tick) begin
          if (dly == DW'(SETTLE_US - 1)) begin
            state <= S_WR;
            step  <= K_BUS_ON;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module mem_reclock_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              busy,
  input logic              done,
  input logic              timeout_err
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_timeout_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done && !busy && !wr_valid);
endmodule

bind mem_reclock_seq mem_reclock_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
  .timeout_err(timeout_err)
);

// File: tb/mem_reclock_seq_tb.sv
module mem_reclock_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DISP = 8'h20, A_BUS = 8'h21, A_PRE = 8'h30, A_REFNOW = 8'h31,
                         A_AUTOREF = 8'h32, A_SELF = 8'h33, A_SRC = 8'h40,
                         A_CTRL = 8'h41, A_COEF = 8'h42;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] target_hz = 32'd0, ctrl_now = 32'd0;
  logic [7:0] pll_n = 8'd0, pll_m = 8'd0;
  logic [2:0] pll_p = 3'd0;
  logic scan_cap = 1'b0, us_tick = 1'b0, wr_ready = 1'b1;
  logic [1:0] head_active = 2'b00, head_scanout = 2'b00, head_vblank = 2'b00;
  logic [15:0] wait_limit = 16'd1000;
  logic wr_valid, busy, done, timeout_err;
  logic [7:0] wr_addr;
  logic [31:0] wr_data;

  int nchecks = 0, nerr = 0;
  int nlog = 0, tick_total = 0, tick_div = 0, rdy_cnt = 0;
  bit stall_mode = 1'b0;
  logic [7:0]  log_addr [0:31];
  logic [31:0] log_data [0:31];
  int          log_tick [0:31];
  logic [7:0]  exp_addr [0:31];
  logic [31:0] exp_data [0:31];
  int nexp = 0;

  mem_reclock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
    .pll_n(pll_n), .pll_m(pll_m), .pll_p(pll_p), .ctrl_now(ctrl_now),
    .scan_cap(scan_cap), .head_active(head_active), .head_scanout(head_scanout),
    .head_vblank(head_vblank), .us_tick(us_tick), .wait_limit(wait_limit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .timeout_err(timeout_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready && nlog < 32) begin
        log_addr[nlog] = wr_addr;
        log_data[nlog] = wr_data;
        log_tick[nlog] = tick_total;
        nlog++;
      end
      if (us_tick) tick_total++;
    end
  end

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 4;
    us_tick = (tick_div == 0) && !wr_valid;
    rdy_cnt++;
    wr_ready = stall_mode ? (rdy_cnt % 3 == 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [31:0] d);
    exp_addr[nexp] = a;
    exp_data[nexp] = d;
    nexp++;
  endtask

  task automatic build_exp(input bit cap, input logic [31:0] tgt, input logic [7:0] n,
                           input logic [7:0] m, input logic [2:0] p, input logic [31:0] c);
    logic [31:0] fin;
    fin = c & ~32'h81FF_0200;
    if (tgt / 1000 == 32'd100000) fin = fin | 32'h200;
    else fin = fin | 32'h8000_0000 | ({29'd0, p} << 22) | ({29'd0, p} << 16);
    nexp = 0;
    if (cap) push(A_DISP, 0);
    push(A_BUS, 0); push(A_PRE, 1); push(A_REFNOW, 1); push(A_AUTOREF, 0); push(A_SELF, 1);
    push(A_SRC, 1); push(A_CTRL, c | 32'h200); push(A_COEF, {16'd0, n, m}); push(A_CTRL, fin);
    push(A_PRE, 1); push(A_SELF, 0); push(A_AUTOREF, 32'h8000_0000); push(A_BUS, 1);
    if (cap) push(A_DISP, 1);
  endtask

  task automatic setup(input bit cap, input logic [31:0] tgt, input logic [7:0] n,
                       input logic [7:0] m, input logic [2:0] p, input logic [31:0] c);
    scan_cap = cap; target_hz = tgt; pll_n = n; pll_m = m; pll_p = p; ctrl_now = c;
    build_exp(cap, tgt, n, m, p, c);
    nlog = 0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    chk(done, {tag, " done pulse"}, {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(!busy, {tag, " busy low after done"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic cmp_log(input string tag);
    chk(nlog == nexp, {tag, " write count"}, nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      chk(log_addr[i] == exp_addr[i], $sformatf("%s addr #%0d", tag, i), {24'd0, log_addr[i]}, {24'd0, exp_addr[i]});
      chk(log_data[i] == exp_data[i], $sformatf("%s data #%0d", tag, i), log_data[i], exp_data[i]);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !wr_valid && !timeout_err, "R1 reset outputs",
        {28'd0, busy, done, wr_valid, timeout_err}, 32'd0);
  endtask

  task automatic t_pll_run();
    setup(1'b1, 32'd400_000_000, 8'h2A, 8'h03, 3'd2, 32'h1234_5678);
    kick();
    wait_done("R10 pll run");
    cmp_log("R3 R4 R5 R7 R9 pll run");
    if (nlog == 15)
      chk(log_tick[13] - log_tick[12] == 60, "R8 settle ticks", log_tick[13] - log_tick[12], 60);
    chk(log_data[9][31] == 1'b1, "R5 pll enable bit", {31'd0, log_data[9][31]}, 32'd1);
  endtask

  task automatic t_ref_run();
    setup(1'b0, 32'd100_000_400, 8'h11, 8'h02, 3'd1, 32'hFFFF_FFFF);
    kick();
    wait_done("R6 ref run");
    cmp_log("R6 R9 ref run no scanout writes");
    chk(nlog > 8 && log_data[8] == 32'h7E00_FFFF | 32'h200, "R6 ref ctrl word", log_data[8], 32'h7E00_FFFF);
    setup(1'b0, 32'd100_001_000, 8'h11, 8'h02, 3'd1, 32'h0000_0000);
    kick();
    wait_done("R6 near ref");
    cmp_log("R6 near ref uses pll");
  endtask

  task automatic t_heads();
    setup(1'b1, 32'd300_000_000, 8'h40, 8'h04, 3'd0, 32'h0000_0100);
    head_active = 2'b01; head_scanout = 2'b10; head_vblank = 2'b10;
    kick();
    repeat (20) @(negedge clk);
    chk(nlog == 0 && !wr_valid, "R2 held before scanout", nlog, 0);
    head_scanout = 2'b01;
    repeat (10) @(negedge clk);
    chk(nlog == 0 && !wr_valid, "R2 held before vblank", nlog, 0);
    head_vblank = 2'b01;
    wait_done("R2 heads");
    cmp_log("R2 heads run");
    head_active = 2'b00; head_scanout = 2'b00; head_vblank = 2'b00;
  endtask

  task automatic t_stall();
    setup(1'b1, 32'd250_000_000, 8'h33, 8'h05, 3'd3, 32'h0F0F_0F0F);
    stall_mode = 1'b1;
    kick();
    repeat (5) @(negedge clk);
    target_hz = 32'd100_000_000; pll_n = 8'h01; ctrl_now = 32'd0; scan_cap = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done("R11 stall run");
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy, "R10 start while busy ignored", {31'd0, busy}, 32'd0);
    cmp_log("R10 R11 stalled run");
  endtask

  task automatic t_timeout();
    int k;
    setup(1'b1, 32'd400_000_000, 8'h2A, 8'h03, 3'd2, 32'd0);
    head_active = 2'b01; head_scanout = 2'b00; wait_limit = 16'd5;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; k = 1;
    while (!done && k < 100) begin @(negedge clk); k++; end
    chk(k == 7, "R12 timeout latency", k, 7);
    chk(timeout_err, "R12 timeout flag", {31'd0, timeout_err}, 32'd1);
    repeat (3) @(negedge clk);
    chk(nlog == 0, "R12 no write on timeout", nlog, 0);
    head_active = 2'b00; wait_limit = 16'd1000;
    setup(1'b0, 32'd400_000_000, 8'h2A, 8'h03, 3'd2, 32'd0);
    kick();
    chk(!timeout_err, "R12 flag cleared at start", {31'd0, timeout_err}, 32'd0);
    wait_done("R12 rerun");
    cmp_log("R12 rerun");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nchecks++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pll_run();
    t_ref_run();
    t_heads();
    t_stall();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule